// File: doc/BRIEF.md
# Interrupt Context Stacking and Return Sequencer

This block sits beside a small 16-bit processor core and runs interrupt entry and return on the core's behalf. When the current instruction retires and an unmasked request is waiting, it captures the core's return address, index registers, accumulator pair and condition byte. It then pushes them as a nine-byte frame onto a stack that grows downward, one byte per cycle, through a byte-wide memory write port. Once the frame is stored it raises the interrupt mask bits and presents the handler vector, together with the new stack pointer, for the core to load.

The core issues a return command when its handler finishes. The sequencer reads the nine bytes back through a read port with one cycle of latency. It presents the restored values to the core and reloads the condition byte, including both mask bits. If a request is still waiting under the restored masks, no second frame is built. The stack pointer is pointed back at the saved condition byte and the next handler's vector is presented straight away.

The condition byte, with its two mask bits, lives in this block. The core updates it through a write strobe while the sequencer is idle.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_we`, `mem_re`, `vec_valid` and `sp_load` are low and `ccr_o` is 8'h50, meaning the request mask (bit 4) and the non-maskable-type mask (bit 6) are set and all other bits are clear.
- R2: An entry starts only at a clock edge where the block is idle, `instr_done` is high and at least one request is unmasked. `irq_req[0]` is gated by `ccr_o` bit 6 and every other request bit is gated by bit 4. `rti_cmd` takes precedence over entry.
- R3: On the accept cycle `flush` pulses high. The frame then occupies the nine bytes from SP-9 to SP-1, where SP is `sp_in` at accept: SP-9 holds the condition byte, SP-8/SP-7 hold D high/low, SP-6/SP-5 hold X high/low, SP-4/SP-3 hold Y high/low and SP-2/SP-1 hold the return address high/low. One byte is written per cycle, highest address first, over nine consecutive cycles with `busy` high.
- R4: The stored condition byte is the value held before entry. After it is written, bit 4 of `ccr_o` is set. Bit 6 is set as well when the winning request is index 0.
- R5: The winner is the lowest-numbered unmasked request at the accept edge, and later request changes do not alter it. In the cycle after the last write, `vec_valid` and `sp_load` pulse for one cycle with `vec_addr` = 16'hFFFE - 2*index and `sp_out` = SP-9, while `busy` is low.
- R6: On `rti_cmd` in idle the block reads the addresses `sp_in` to `sp_in+8`, one per cycle. `mem_rdata` is expected one cycle after `mem_re`. Ten cycles after the command edge, `rest_valid` pulses with `rest_pc`, `rest_y`, `rest_x` and `rest_d` rebuilt from the frame layout of R3. No memory write occurs during a return.
- R7: If no request is unmasked under the masks of the restored condition byte, `sp_load` pulses together with `rest_valid` with `sp_out` = `sp_in`+9, and `ccr_o` then equals the restored byte.
- R8: If a request is unmasked under the restored masks, `sp_load` stays low during `rest_valid`. In the next cycle `vec_valid` and `sp_load` pulse with that winner's vector and `sp_out` = `sp_in`. `ccr_o` is then the restored byte with bit 4 set, and with bit 6 set too if the winner is index 0.
- R9: `ccr_wr_en` loads `ccr_wdata` into `ccr_o` while the block is idle and not starting a sequence. It has no effect while `busy` is high.
- R10: A reset asserted in the middle of stacking stops all further writes and returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Current instruction retires this cycle |
| rti_cmd | input | 1 | Return-from-interrupt command |
| irq_req | input | 8 | Request lines, index 0 non-maskable type, lower index wins |
| ccr_wr_en | input | 1 | Core writes the condition byte |
| ccr_wdata | input | 8 | Condition byte value from the core |
| pc_in | input | 16 | Return address computed by the core |
| y_in | input | 16 | Y index register |
| x_in | input | 16 | X index register |
| d_in | input | 16 | Accumulator pair (high byte first) |
| sp_in | input | 16 | Current stack pointer |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Stack byte read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, one cycle after mem_re |
| busy | output | 1 | Sequence in progress |
| flush | output | 1 | Clear the core's instruction queue |
| vec_valid | output | 1 | Handler vector address is valid |
| vec_addr | output | 16 | Address of the handler vector |
| sp_load | output | 1 | Core loads sp_out into its stack pointer |
| sp_out | output | 16 | New stack pointer value |
| rest_valid | output | 1 | Restored register values are valid |
| rest_pc | output | 16 | Restored return address |
| rest_y | output | 16 | Restored Y |
| rest_x | output | 16 | Restored X |
| rest_d | output | 16 | Restored accumulator pair |
| ccr_o | output | 8 | Condition byte including both mask bits |

## Verification
Entry is tried with single requests, with several simultaneous requests, with requests that are masked by one mask bit but not the other, and with a new higher-priority request raised during stacking. Together these separate priority order, per-index masking and the freezing of the winner at accept. Return is tried with no request, with a request that the restored byte masks, and with one it leaves open, which separates plain return from chaining and confirms that the decision uses the restored masks rather than the live ones. Random register values, stack pointers and condition bytes catch byte-order and address slips. A condition-byte write issued during stacking, and a reset in the middle of a frame, check the ignore and abandon rules.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STK   = 3'd1,
    S_VEC   = 3'd2,
    S_RD    = 3'd3,
    S_RDONE = 3'd4
  } seq_st_t;

  // frame byte count; offset 0 is the condition byte at the lowest address
  localparam int FRAME_BYTES = 9;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  parameter int AW = 16,
  parameter int IPOS = 4,
  parameter int XPOS = 6,
  parameter logic [AW-1:0] VEC_TOP = 16'hFFFE,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [7:0]    ccr,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [AW-1:0] vec
);
  logic [N-1:0] gated;

  // index 0 obeys the non-maskable-type mask, all others the request mask
  for (genvar g = 0; g < N; g++) begin : g_gate
    if (g == 0) begin : g_x
      assign gated[g] = req[g] & ~ccr[XPOS];
    end else begin : g_i
      assign gated[g] = req[g] & ~ccr[IPOS];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gated[i]) idx = IW'(i);
    end
  end

  assign any = |gated;
  assign vec = VEC_TOP - ({{(AW-IW){1'b0}}, idx} << 1);
endmodule

// File: rtl/irq_frame_buf.sv
module irq_frame_buf import irq_seq_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic [15:0] ld_pc,
  input  logic [15:0] ld_y,
  input  logic [15:0] ld_x,
  input  logic [15:0] ld_d,
  input  logic [7:0]  ld_ccr,
  input  logic        cap_en,
  input  logic [3:0]  cap_off,
  input  logic [7:0]  cap_data,
  input  logic [3:0]  sel_off,
  output logic [7:0]  sel_byte,
  output logic [15:0] f_pc,
  output logic [15:0] f_y,
  output logic [15:0] f_x,
  output logic [15:0] f_d,
  output logic [7:0]  f_ccr
);
  logic [FRAME_BYTES-1:0][7:0] fb_q, fb_d;

  always_comb begin
    fb_d = fb_q;
    if (load_en) begin
      fb_d = {ld_pc[7:0], ld_pc[15:8], ld_y[7:0], ld_y[15:8],
              ld_x[7:0], ld_x[15:8], ld_d[7:0], ld_d[15:8], ld_ccr};
    end else if (cap_en) begin
      for (int i = 0; i < FRAME_BYTES; i++) begin
        if (cap_off == 4'(i)) fb_d[i] = cap_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fb_q <= '0;
    else if (load_en || cap_en) fb_q <= fb_d;
  end

  always_comb begin
    sel_byte = 8'h00;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (sel_off == 4'(i)) sel_byte = fb_q[i];
    end
  end

  assign f_ccr = fb_q[0];
  assign f_d   = {fb_q[1], fb_q[2]};
  assign f_x   = {fb_q[3], fb_q[4]};
  assign f_y   = {fb_q[5], fb_q[6]};
  assign f_pc  = {fb_q[7], fb_q[8]};
endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl import irq_seq_pkg::*; #(
  parameter int N = 8,
  parameter int AW = 16,
  parameter int IPOS = 4,
  parameter int XPOS = 6,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          rti_cmd,
  input  logic          ccr_wr_en,
  input  logic [7:0]    ccr_wdata,
  input  logic [AW-1:0] sp_in,
  input  logic          pend_any,
  input  logic [IW-1:0] pend_idx,
  input  logic [AW-1:0] pend_vec,
  input  logic [7:0]    frame_ccr,
  output logic          busy,
  output logic          flush,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    sel_off,
  output logic          load_en,
  output logic          cap_en,
  output logic [3:0]    cap_off,
  output logic [7:0]    ccr_q,
  output logic [7:0]    eff_ccr,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          sp_load,
  output logic [AW-1:0] sp_out,
  output logic          rest_valid
);
  localparam logic [7:0] IMSK     = 8'(1) << IPOS;
  localparam logic [7:0] XMSK     = 8'(1) << XPOS;
  localparam logic [3:0] LAST_OFF = 4'(FRAME_BYTES - 1);
  localparam logic [3:0] RD_END   = 4'(FRAME_BYTES);

  seq_st_t       state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] vec_q, vec_d;
  logic          xwin_q, xwin_d;
  logic [7:0]    ccr_d;
  logic [AW-1:0] cnt_ext;

  assign cnt_ext = {{(AW-4){1'b0}}, cnt_q};
  // masks that decide a chained handler come from the frame being restored
  assign eff_ccr = (state_q == S_RDONE) ? frame_ccr : ccr_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    base_d     = base_q;
    vec_d      = vec_q;
    xwin_d     = xwin_q;
    ccr_d      = ccr_q;
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    mem_addr   = base_q + cnt_ext;
    load_en    = 1'b0;
    cap_en     = 1'b0;
    cap_off    = cnt_q - 4'd1;
    flush      = 1'b0;
    vec_valid  = 1'b0;
    sp_load    = 1'b0;
    sp_out     = base_q;
    rest_valid = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (rti_cmd) begin
          base_d  = sp_in;
          cnt_d   = 4'd0;
          state_d = S_RD;
        end else if (instr_done && pend_any) begin
          base_d  = sp_in - AW'(FRAME_BYTES);
          vec_d   = pend_vec;
          xwin_d  = (pend_idx == '0);
          load_en = 1'b1;
          flush   = 1'b1;
          cnt_d   = LAST_OFF;
          state_d = S_STK;
        end else if (ccr_wr_en) begin
          ccr_d = ccr_wdata;
        end
      end
      S_STK: begin
        mem_we = 1'b1;
        if (cnt_q == 4'd0) begin
          ccr_d   = ccr_q | IMSK | (xwin_q ? XMSK : 8'h00);
          state_d = S_VEC;
        end else begin
          cnt_d = cnt_q - 4'd1;
        end
      end
      S_VEC: begin
        vec_valid = 1'b1;
        sp_load   = 1'b1;
        state_d   = S_IDLE;
      end
      S_RD: begin
        mem_re = (cnt_q < RD_END);
        cap_en = (cnt_q != 4'd0);
        if (cnt_q == RD_END) state_d = S_RDONE;
        else                 cnt_d   = cnt_q + 4'd1;
      end
      S_RDONE: begin
        rest_valid = 1'b1;
        if (pend_any) begin
          ccr_d   = frame_ccr | IMSK | ((pend_idx == '0) ? XMSK : 8'h00);
          vec_d   = pend_vec;
          flush   = 1'b1;
          state_d = S_VEC;
        end else begin
          ccr_d   = frame_ccr;
          sp_load = 1'b1;
          sp_out  = base_q + AW'(FRAME_BYTES);
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      vec_q   <= '0;
      xwin_q  <= 1'b0;
      ccr_q   <= IMSK | XMSK;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      vec_q   <= vec_d;
      xwin_q  <= xwin_d;
      ccr_q   <= ccr_d;
    end
  end

  assign busy     = (state_q == S_STK) || (state_q == S_RD) || (state_q == S_RDONE);
  assign sel_off  = cnt_q;
  assign vec_addr = vec_q;

  // R3
  write_addr_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  // R2
  write_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(instr_done));

  // R4
  imask_after_ccr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cnt_q == 4'd0) |=> ccr_q[IPOS]);

  // R5
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (!vec_valid && !busy));

  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R6
  capture_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> $past(mem_re));
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq #(
  parameter int N = 8,
  parameter int AW = 16,
  parameter int IPOS = 4,
  parameter int XPOS = 6,
  parameter logic [AW-1:0] VEC_TOP = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          rti_cmd,
  input  logic [N-1:0]  irq_req,
  input  logic          ccr_wr_en,
  input  logic [7:0]    ccr_wdata,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   y_in,
  input  logic [15:0]   x_in,
  input  logic [15:0]   d_in,
  input  logic [AW-1:0] sp_in,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          flush,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          sp_load,
  output logic [AW-1:0] sp_out,
  output logic          rest_valid,
  output logic [15:0]   rest_pc,
  output logic [15:0]   rest_y,
  output logic [15:0]   rest_x,
  output logic [15:0]   rest_d,
  output logic [7:0]    ccr_o
);
  localparam int IW = $clog2(N);

  logic          rst_i_n;
  logic          pend_any;
  logic [IW-1:0] pend_idx;
  logic [AW-1:0] pend_vec;
  logic [7:0]    eff_ccr;
  logic [7:0]    frame_ccr;
  logic [3:0]    sel_off;
  logic [3:0]    cap_off;
  logic          load_en;
  logic          cap_en;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  irq_prio_enc #(
    .N(N), .AW(AW), .IPOS(IPOS), .XPOS(XPOS), .VEC_TOP(VEC_TOP)
  ) u_enc (
    .req (irq_req),
    .ccr (eff_ccr),
    .any (pend_any),
    .idx (pend_idx),
    .vec (pend_vec)
  );

  irq_frame_buf u_buf (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (load_en),
    .ld_pc    (pc_in),
    .ld_y     (y_in),
    .ld_x     (x_in),
    .ld_d     (d_in),
    .ld_ccr   (ccr_o),
    .cap_en   (cap_en),
    .cap_off  (cap_off),
    .cap_data (mem_rdata),
    .sel_off  (sel_off),
    .sel_byte (mem_wdata),
    .f_pc     (rest_pc),
    .f_y      (rest_y),
    .f_x      (rest_x),
    .f_d      (rest_d),
    .f_ccr    (frame_ccr)
  );

  irq_seq_ctl #(
    .N(N), .AW(AW), .IPOS(IPOS), .XPOS(XPOS)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .instr_done (instr_done),
    .rti_cmd    (rti_cmd),
    .ccr_wr_en  (ccr_wr_en),
    .ccr_wdata  (ccr_wdata),
    .sp_in      (sp_in),
    .pend_any   (pend_any),
    .pend_idx   (pend_idx),
    .pend_vec   (pend_vec),
    .frame_ccr  (frame_ccr),
    .busy       (busy),
    .flush      (flush),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .sel_off    (sel_off),
    .load_en    (load_en),
    .cap_en     (cap_en),
    .cap_off    (cap_off),
    .ccr_q      (ccr_o),
    .eff_ccr    (eff_ccr),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr),
    .sp_load    (sp_load),
    .sp_out     (sp_out),
    .rest_valid (rest_valid)
  );
endmodule

// File: tb/irq_frame_seq_bench.sv
module irq_frame_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0, rti_cmd = 1'b0, ccr_wr_en = 1'b0;
  logic [7:0]  irq_req = 8'h00, ccr_wdata = 8'h00;
  logic [15:0] pc_in = 16'h0, y_in = 16'h0, x_in = 16'h0, d_in = 16'h0, sp_in = 16'h0;
  logic        mem_we, mem_re, busy, flush, vec_valid, sp_load, rest_valid;
  logic [15:0] mem_addr, vec_addr, sp_out, rest_pc, rest_y, rest_x, rest_d;
  logic [7:0]  mem_wdata, ccr_o;
  logic [7:0]  mem_rdata = 8'h00;

  logic [7:0]  mem [0:1023];
  int          wr_cnt = 0;
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [7:0]  pre_data = '0;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_frame_seq u_irq_frame_seq (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .rti_cmd(rti_cmd),
    .irq_req(irq_req), .ccr_wr_en(ccr_wr_en), .ccr_wdata(ccr_wdata),
    .pc_in(pc_in), .y_in(y_in), .x_in(x_in), .d_in(d_in), .sp_in(sp_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .flush(flush), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .sp_load(sp_load), .sp_out(sp_out), .rest_valid(rest_valid),
    .rest_pc(rest_pc), .rest_y(rest_y), .rest_x(rest_x), .rest_d(rest_d), .ccr_o(ccr_o)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (pre_we) mem[pre_addr] <= pre_data;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // lowest unmasked index; index 0 masked by bit 6, others by bit 4
  function automatic int winner(logic [7:0] rq, logic [7:0] c);
    for (int i = 0; i < 8; i++) begin
      if (rq[i] && !((i == 0) ? c[6] : c[4])) return i;
    end
    return -1;
  endfunction

  function automatic logic [71:0] frame_of(logic [15:0] pc, logic [15:0] yv,
      logic [15:0] xv, logic [15:0] dv, logic [7:0] c);
    return {pc[7:0], pc[15:8], yv[7:0], yv[15:8], xv[7:0], xv[15:8], dv[7:0], dv[15:8], c};
  endfunction

  task automatic set_ccr(input logic [7:0] v);
    @(negedge clk);
    ccr_wr_en = 1'b1; ccr_wdata = v;
    @(negedge clk);
    ccr_wr_en = 1'b0;
    chk(ccr_o == v, "R9", "ccr write in idle", ccr_o, v);
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [15:0] yv, input logic [15:0] xv,
      input logic [15:0] dv, input logic [15:0] sp, input logic [7:0] rq,
      input bit late, input bit wr_busy);
    int idx, w, busy_n, wr0;
    logic [7:0]  c0, cexp;
    logic [71:0] actf;
    @(negedge clk);
    pc_in = pc; y_in = yv; x_in = xv; d_in = dv; sp_in = sp;
    irq_req = rq; instr_done = 1'b1;
    c0 = ccr_o; idx = winner(rq, c0); wr0 = wr_cnt;
    #1;
    chk(flush == (idx >= 0), "R3", "flush on accept", 72'(flush), 72'(idx >= 0));
    @(negedge clk);
    instr_done = 1'b0;
    if (late) irq_req = 8'hFF;
    if (wr_busy) begin ccr_wr_en = 1'b1; ccr_wdata = 8'h00; end
    if (idx < 0) begin
      irq_req = 8'h00;
      repeat (3) @(negedge clk);
      chk(!busy && wr_cnt == wr0, "R2", "masked request not accepted",
          72'(wr_cnt - wr0), 72'(0));
      return;
    end
    busy_n = 0; w = 0;
    while (!vec_valid && w < 40) begin
      if (busy) busy_n++;
      @(negedge clk);
      w++;
      if (w == 3) begin irq_req = 8'h00; ccr_wr_en = 1'b0; end
    end
    irq_req = 8'h00; ccr_wr_en = 1'b0;
    for (int k = 0; k < 9; k++) actf[8*k +: 8] = mem[10'(sp - 16'd9 + 16'(k))];
    chk(actf == frame_of(pc, yv, xv, dv, c0), "R3", "frame bytes", actf, frame_of(pc, yv, xv, dv, c0));
    chk(busy_n == 9 && wr_cnt - wr0 == 9, "R3", "nine write cycles", 72'(busy_n), 72'(9));
    chk(vec_valid && vec_addr == 16'hFFFE - 16'(2 * idx), "R5", "vector address",
        72'(vec_addr), 72'(16'hFFFE - 16'(2 * idx)));
    chk(sp_load && sp_out == sp - 16'd9 && !busy, "R5", "stack pointer after entry",
        72'(sp_out), 72'(sp - 16'd9));
    cexp = c0 | 8'h10 | ((idx == 0) ? 8'h40 : 8'h00);
    chk(ccr_o == cexp, wr_busy ? "R9" : "R4", "mask bits after entry", 72'(ccr_o), 72'(cexp));
    @(negedge clk);
  endtask

  task automatic do_rti(input logic [15:0] pc, input logic [15:0] yv, input logic [15:0] xv,
      input logic [15:0] dv, input logic [15:0] sp, input logic [7:0] c, input logic [7:0] rq);
    logic [71:0] f;
    int idx, w, wr0;
    logic [7:0] cexp;
    f = frame_of(pc, yv, xv, dv, c);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 10'(sp + 16'(k)); pre_data = f[8*k +: 8];
    end
    @(negedge clk);
    pre_we = 1'b0;
    sp_in = sp; irq_req = rq; rti_cmd = 1'b1; instr_done = 1'b1;
    wr0 = wr_cnt;
    @(negedge clk);
    rti_cmd = 1'b0; instr_done = 1'b0;
    w = 0;
    while (!rest_valid && w < 40) begin @(negedge clk); w++; end
    chk(w == 10, "R6", "return latency", 72'(w), 72'(10));
    chk({rest_pc, rest_y, rest_x, rest_d} == {pc, yv, xv, dv}, "R6", "restored registers",
        72'({rest_pc, rest_y, rest_x, rest_d}), 72'({pc, yv, xv, dv}));
    idx = winner(rq, c);
    if (idx < 0) begin
      chk(sp_load && sp_out == sp + 16'd9, "R7", "stack pointer after return",
          72'(sp_out), 72'(sp + 16'd9));
      @(negedge clk);
      chk(ccr_o == c && !vec_valid, "R7", "restored ccr", 72'(ccr_o), 72'(c));
    end else begin
      chk(!sp_load, "R8", "no stack load at restore when chaining", 72'(sp_load), 72'(0));
      @(negedge clk);
      cexp = c | 8'h10 | ((idx == 0) ? 8'h40 : 8'h00);
      chk(vec_valid && sp_load && sp_out == sp && vec_addr == 16'hFFFE - 16'(2 * idx),
          "R8", "chained vector and stack pointer", 72'({vec_addr, sp_out}),
          72'({16'hFFFE - 16'(2 * idx), sp}));
      chk(ccr_o == cexp, "R8", "chained mask bits", 72'(ccr_o), 72'(cexp));
    end
    irq_req = 8'h00;
    chk(wr_cnt == wr0, "R6", "no writes on return", 72'(wr_cnt - wr0), 72'(0));
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int wr0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_we && !mem_re && !vec_valid && !sp_load && ccr_o == 8'h50,
        "R1", "reset state", 72'(ccr_o), 72'h50);

    // R2 masked by bit 4, then no boundary
    do_entry(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0200, 8'h08, 0, 0);
    set_ccr(8'h00);
    @(negedge clk);
    irq_req = 8'h04; wr0 = wr_cnt;
    repeat (3) @(negedge clk);
    chk(!busy && wr_cnt == wr0, "R2", "no accept without instr_done", 72'(busy), 72'(0));
    irq_req = 8'h00;

    // R5 winner frozen, R9 write ignored while busy
    do_entry(16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718, 16'h0300, 8'h0C, 1, 1);
    // only index 0 open when bit 4 set, bit 6 clear (R2, R4)
    set_ccr(8'h10);
    do_entry(16'h4455, 16'h6677, 16'h8899, 16'hAABB, 16'h0280, 8'h07, 0, 0);

    // R7 plain return, R8 chain, R7 chain blocked by restored mask
    do_rti(16'h1357, 16'h2468, 16'h369C, 16'h48AD, 16'h0180, 8'h00, 8'h00);
    do_rti(16'h0F0E, 16'h0D0C, 16'h0B0A, 16'h0908, 16'h0190, 8'h01, 8'h20);
    do_rti(16'h7766, 16'h5544, 16'h3322, 16'h1100, 16'h01A0, 8'h10, 8'h20);
    do_rti(16'hCAFE, 16'hBEEF, 16'hF00D, 16'h1357, 16'h01B0, 8'h10, 8'h21);

    // R10 reset in the middle of stacking
    set_ccr(8'h00);
    @(negedge clk);
    sp_in = 16'h0240; irq_req = 8'h02; instr_done = 1'b1; wr0 = wr_cnt;
    @(negedge clk);
    instr_done = 1'b0; irq_req = 8'h00;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(wr_cnt - wr0 == 2 && !busy && ccr_o == 8'h50, "R10", "abandoned frame",
        72'({8'(wr_cnt - wr0), ccr_o}), 72'({8'd2, 8'h50}));

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [15:0] rsp;
      logic [7:0]  rq, rc;
      rsp = 16'h0040 + 16'($urandom % 32'h0380);
      rq  = 8'($urandom);
      if ($urandom % 3 == 0) rq = rq & 8'h81;
      rc  = 8'($urandom) & 8'hAF;
      if ($urandom % 2 == 0) begin
        set_ccr(rc);
        do_entry(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), rsp, rq, 0, 0);
      end else begin
        do_rti(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), rsp, rc | 8'(($urandom % 4) << 4), rq);
      end
    end
    finish_run();
  end
endmodule